// File: doc/BRIEF.md
# Access-Port Register Sequencer

This block sits between a debug host controller and a serial-wire transaction engine. A host asks for one access-port register read or write, or for one of two abort commands, and the block expands that request into the short series of debug-port transactions that carry it out. It hands each transaction to the engine as a request byte and a 32-bit word, then waits for the engine's acknowledge before it moves on.

The 16-bit operation address packs three fields. The upper byte selects the access port and bits 7:4 select the register bank; both go into the bank-select word. Bits 3:2 pick the register inside the bank. Every register access ends with a read of the debug-port read buffer, for writes as well as for reads. As a result, a stalled or faulted access shows up before the block reports completion, and a read returns the completed value rather than the pipelined one. Only one operation runs at a time. A one-cycle done pulse carries the final acknowledge code and, for reads, the data.

Top module: `apseq_top`

## Requirements
- R1: While reset is held, and in the cycle after it, `op_ready` is 1 and both `xact_req` and `op_done` are 0.
- R2: Every request byte has bit 0 = 1 (start), bit 1 = port select (1 = access port), bit 2 = direction (1 = read), bits 4:3 = register address A[3:2], bit 5 = XOR of bits 4:1, bit 6 = 0 and bit 7 = 1.
- R3: The first step of a register operation is a debug-port write to address 0x8 (byte 0xB1). Its word carries `op_addr[15:8]` in bits 31:24 and `op_addr[7:4]` in bits 7:4, with every other bit 0.
- R4: The access-port step sets the port-select bit and uses `op_addr[3:2]` as its register address.
- R5: A write (`op_kind` = 1) issues exactly three steps in this order: bank select, access-port write carrying `op_wdata`, and a debug-port read of address 0xC (byte 0xBD).
- R6: A read (`op_kind` = 0) issues bank select, an access-port read and the 0xC read-buffer read, in that order. `op_rdata` returns the data of the read-buffer step, not the data of the access-port step.
- R7: `op_kind` = 2 issues one debug-port write to address 0 (byte 0x81) with word 0x0000001E. `op_kind` = 3 issues the same write with word 0x0000001F.
- R8: Acknowledge codes are 3'b001 OK, 3'b010 WAIT and 3'b100 FAULT. Any code other than OK ends the operation at that step, with no further request, and is returned in `op_status`. `op_rdata` is then 0.
- R9: `xact_req`, `xact_cmd` and `xact_wdata` stay steady until a cycle in which `xact_ack` is 1. The next step's request is presented in the cycle that follows.
- R10: `op_done` is a single-cycle pulse one cycle after the acknowledge of the final step. `op_ready` is 1 in that same cycle.
- R11: An `op_start` while `op_ready` is 0 is ignored and adds no request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| op_start | input | 1 | Start an operation; taken only when `op_ready` is 1 |
| op_kind | input | 2 | 0 register read, 1 register write, 2 clear sticky errors, 3 abort access port |
| op_addr | input | 16 | Packed port / bank / register address |
| op_wdata | input | 32 | Data for a register write |
| op_ready | output | 1 | No operation in flight |
| op_done | output | 1 | One-cycle completion pulse |
| op_status | output | 3 | Final acknowledge code |
| op_rdata | output | 32 | Read result (valid with `op_done` on a successful read) |
| xact_req | output | 1 | Transaction request to the engine |
| xact_cmd | output | 8 | Request byte including parity |
| xact_wdata | output | 32 | Word to write for write transactions |
| xact_ack | input | 1 | Engine has finished the current transaction |
| xact_status | input | 3 | Acknowledge code of the finished transaction |
| xact_rdata | input | 32 | Data of the finished read transaction |

## Verification
A request appears one cycle after `op_start` is accepted, or one cycle after the previous step's acknowledge. `op_done` rises one cycle after the acknowledge of the last step, and `op_ready` returns in that same cycle. The bench's engine model serves requests at several latencies and logs them. A reference model in the bench predicts `op_done` and `op_ready` for every clock, and the comparison is sampled a quarter period after each rising edge. The logged request sequence, the returned status and the read data are then compared with the per-requirement expectations at the done pulse.

// File: rtl/apseq_pkg.sv
// Package: shared widths, operation and step encodings, fixed request fields.
// Assumes a 32-bit data path and 3-bit acknowledge codes.
package apseq_pkg;
    localparam int DATA_W = 32;
    localparam int ADDR_W = 16;
    localparam int ACK_W  = 3;
    localparam int CMD_W  = 8;
    localparam int REGA_W = 2;

    localparam logic [ACK_W-1:0] ACK_OK = 3'b001;

    // Debug-port register addresses (A[3:2]) used by the sequence
    localparam logic [REGA_W-1:0] DPA_ABORT  = 2'b00;
    localparam logic [REGA_W-1:0] DPA_BANK   = 2'b10;
    localparam logic [REGA_W-1:0] DPA_RDBUF  = 2'b11;

    // Abort-register payloads
    localparam logic [7:0] ABT_CLR_STICKY = 8'h1E;
    localparam logic [7:0] ABT_ABORT_AP   = 8'h01;

    // Request bytes the interface checks rely on
    localparam logic [CMD_W-1:0] CMD_BANK_WR = 8'hB1;
    localparam logic [CMD_W-1:0] CMD_ABT_WR  = 8'h81;

    typedef enum logic [1:0] {
        OP_APRD   = 2'd0,
        OP_APWR   = 2'd1,
        OP_CLRERR = 2'd2,
        OP_ABORT  = 2'd3
    } op_kind_e;

    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_BANK = 3'd1,
        ST_AP   = 3'd2,
        ST_BUF  = 3'd3,
        ST_ABT  = 3'd4
    } step_e;
endpackage

// File: rtl/apseq_reqbyte.sv
// Request-byte builder: packs port select, direction and register address
// with start, stop, park and even parity. Purely combinational.
module apseq_reqbyte
    import apseq_pkg::*;
(
    input  logic              port_ap,
    input  logic              is_read,
    input  logic [REGA_W-1:0] reg_a,
    output logic [CMD_W-1:0]  cmd
);
    logic par;

    // Parity covers port select, direction and both address bits
    always_comb par = port_ap ^ is_read ^ reg_a[0] ^ reg_a[1];

    // Field placement: park, stop, parity, A3, A2, direction, port, start
    always_comb cmd = {1'b1, 1'b0, par, reg_a[1], reg_a[0], is_read, port_ap, 1'b1};
endmodule

// File: rtl/apseq_payload.sv
// Step decoder: for the current step and the latched operation, gives the
// request fields and the word to write. Assumes operands are stable while busy.
module apseq_payload
    import apseq_pkg::*;
(
    input  step_e              step,
    input  op_kind_e           kind,
    input  logic [ADDR_W-1:0]  addr,
    input  logic [DATA_W-1:0]  wdata,
    output logic               port_ap,
    output logic               is_read,
    output logic [REGA_W-1:0]  reg_a,
    output logic [DATA_W-1:0]  word
);
    localparam int PORT_LSB = DATA_W - 8;
    localparam int ZERO_MID = PORT_LSB - 8;

    logic [DATA_W-1:0] bank_word;
    logic [7:0]        abt_byte;

    // Bank-select word: port number on top, bank nibble at bits 7:4
    always_comb bank_word = {addr[15:8], {ZERO_MID{1'b0}}, addr[7:4], 4'b0000};

    // Abort payload differs only in the abort-port bit
    always_comb abt_byte = ABT_CLR_STICKY | ((kind == OP_ABORT) ? ABT_ABORT_AP : 8'h00);

    // Per-step field selection
    always_comb begin
        port_ap = 1'b0;
        is_read = 1'b0;
        reg_a   = '0;
        word    = '0;
        case (step)
            ST_BANK: begin
                reg_a = DPA_BANK;
                word  = bank_word;
            end
            ST_AP: begin
                port_ap = 1'b1;
                is_read = (kind == OP_APRD);
                reg_a   = addr[3:2];
                word    = (kind == OP_APWR) ? wdata : '0;
            end
            ST_BUF: begin
                is_read = 1'b1;
                reg_a   = DPA_RDBUF;
            end
            ST_ABT: begin
                reg_a = DPA_ABORT;
                word  = {{(DATA_W-8){1'b0}}, abt_byte};
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/apseq_ctrl.sv
// Step controller: accepts one operation at a time, walks its steps on each
// engine acknowledge, stops at the first non-OK code, and pulses done.
// Assumes the engine raises ack only while a request is presented.
module apseq_ctrl
    import apseq_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               op_start,
    input  op_kind_e           op_kind,
    input  logic [ADDR_W-1:0]  op_addr,
    input  logic [DATA_W-1:0]  op_wdata,
    input  logic               xact_ack,
    input  logic [ACK_W-1:0]   xact_status,
    input  logic [DATA_W-1:0]  xact_rdata,
    output step_e              step,
    output op_kind_e           kind_q,
    output logic [ADDR_W-1:0]  addr_q,
    output logic [DATA_W-1:0]  wdata_q,
    output logic               op_ready,
    output logic               op_done,
    output logic [ACK_W-1:0]   op_status,
    output logic [DATA_W-1:0]  op_rdata
);
    logic last_step;
    logic is_abort;

    // Final step of a sequence: read-buffer read or abort write
    always_comb last_step = (step == ST_BUF) || (step == ST_ABT);
    always_comb is_abort  = (op_kind == OP_CLRERR) || (op_kind == OP_ABORT);
    always_comb op_ready  = (step == ST_IDLE);

    // Sequencing, operand capture and completion reporting
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            step      <= ST_IDLE;
            kind_q    <= OP_APRD;
            addr_q    <= '0;
            wdata_q   <= '0;
            op_done   <= 1'b0;
            op_status <= '0;
            op_rdata  <= '0;
        end else begin
            op_done <= 1'b0;
            if (step == ST_IDLE) begin
                if (op_start) begin
                    kind_q  <= op_kind;
                    addr_q  <= op_addr;
                    wdata_q <= op_wdata;
                    step    <= is_abort ? ST_ABT : ST_BANK;
                end
            end else if (xact_ack) begin
                if ((xact_status != ACK_OK) || last_step) begin
                    step      <= ST_IDLE;
                    op_done   <= 1'b1;
                    op_status <= xact_status;
                    op_rdata  <= ((xact_status == ACK_OK) && (step == ST_BUF) && (kind_q == OP_APRD))
                                 ? xact_rdata : '0;
                end else begin
                    step <= (step == ST_BANK) ? ST_AP : ST_BUF;
                end
            end
        end
    end

    // R11: a start while busy leaves the latched operation untouched
    a_r11_busy_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (!op_ready && op_start) |=> $stable(kind_q) && $stable(addr_q) && $stable(wdata_q));
endmodule

// File: rtl/apseq_top.sv
// Access-port register sequencer top: wires the controller, the step decoder
// and the request-byte builder, and guards the engine-side handshake.
// Assumes a single engine that acknowledges each request exactly once.
module apseq_top
    import apseq_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               op_start,
    input  logic [1:0]         op_kind,
    input  logic [ADDR_W-1:0]  op_addr,
    input  logic [DATA_W-1:0]  op_wdata,
    output logic               op_ready,
    output logic               op_done,
    output logic [ACK_W-1:0]   op_status,
    output logic [DATA_W-1:0]  op_rdata,
    output logic               xact_req,
    output logic [CMD_W-1:0]   xact_cmd,
    output logic [DATA_W-1:0]  xact_wdata,
    input  logic               xact_ack,
    input  logic [ACK_W-1:0]   xact_status,
    input  logic [DATA_W-1:0]  xact_rdata
);
    step_e              step;
    op_kind_e           kind_q;
    logic [ADDR_W-1:0]  addr_q;
    logic [DATA_W-1:0]  wdata_q;
    logic               port_ap;
    logic               is_read;
    logic [REGA_W-1:0]  reg_a;

    apseq_ctrl u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .op_start   (op_start),
        .op_kind    (op_kind_e'(op_kind)),
        .op_addr    (op_addr),
        .op_wdata   (op_wdata),
        .xact_ack   (xact_ack),
        .xact_status(xact_status),
        .xact_rdata (xact_rdata),
        .step       (step),
        .kind_q     (kind_q),
        .addr_q     (addr_q),
        .wdata_q    (wdata_q),
        .op_ready   (op_ready),
        .op_done    (op_done),
        .op_status  (op_status),
        .op_rdata   (op_rdata)
    );

    apseq_payload u_payload (
        .step   (step),
        .kind   (kind_q),
        .addr   (addr_q),
        .wdata  (wdata_q),
        .port_ap(port_ap),
        .is_read(is_read),
        .reg_a  (reg_a),
        .word   (xact_wdata)
    );

    apseq_reqbyte u_reqbyte (
        .port_ap(port_ap),
        .is_read(is_read),
        .reg_a  (reg_a),
        .cmd    (xact_cmd)
    );

    // A request is outstanding whenever a step is active
    always_comb xact_req = (step != ST_IDLE);

    // R1: reset leaves the block idle with no request and no done
    a_r1_idle_after_reset: assert property (@(posedge clk)
        !rst_n |=> op_ready && !xact_req && !op_done);

    // R2: framing bits and even parity of every request byte
    a_r2_byte_frame: assert property (@(posedge clk) disable iff (!rst_n)
        xact_req |-> xact_cmd[0] && !xact_cmd[6] && xact_cmd[7] && !(^xact_cmd[5:1]));

    // R3: bank-select word keeps unused bits clear
    a_r3_bank_word_clean: assert property (@(posedge clk) disable iff (!rst_n)
        (xact_req && xact_cmd == CMD_BANK_WR) |-> (xact_wdata[23:8] == '0) && (xact_wdata[3:0] == '0));

    // R7: abort writes carry the sticky-clear bits
    a_r7_abort_payload: assert property (@(posedge clk) disable iff (!rst_n)
        (xact_req && xact_cmd == CMD_ABT_WR) |-> (xact_wdata[DATA_W-1:5] == '0) && (xact_wdata[4:1] == 4'hF));

    // R9: request held steady until acknowledged
    a_r9_hold_until_ack: assert property (@(posedge clk) disable iff (!rst_n)
        (xact_req && !xact_ack) |=> xact_req && $stable(xact_cmd) && $stable(xact_wdata));

    // R8: a non-OK code ends the sequence and is reported
    a_r8_stop_on_error: assert property (@(posedge clk) disable iff (!rst_n)
        (xact_req && xact_ack && xact_status != ACK_OK) |=> op_done && !xact_req && (op_status == $past(xact_status)));

    // R10: done is a single-cycle pulse seen with ready
    a_r10_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        op_done |-> op_ready ##1 !op_done);
endmodule

// File: tb/apseq_top_tb.sv
// Bench: engine model with scripted latency and codes, per-clock reference
// model of ready and done, and per-operation checks of the request sequence.
module apseq_top_tb;
    localparam int CLK_P = 10;
    localparam logic [2:0] OK = 3'b001, WT = 3'b010, FT = 3'b100;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        op_start = 1'b0;
    logic [1:0]  op_kind = 2'd0;
    logic [15:0] op_addr = '0;
    logic [31:0] op_wdata = '0;
    logic        op_ready, op_done;
    logic [2:0]  op_status;
    logic [31:0] op_rdata;
    logic        xact_req;
    logic [7:0]  xact_cmd;
    logic [31:0] xact_wdata;
    logic        xact_ack = 1'b0;
    logic [2:0]  xact_status = 3'b000;
    logic [31:0] xact_rdata = '0;

    int n_tests = 0, n_fail = 0;

    apseq_top u_dut (.*);

    always #(CLK_P/2) clk = ~clk;

    // Scripted engine responses and request log
    int          rsp_lat[$];
    logic [2:0]  rsp_st[$];
    logic [31:0] rsp_dat[$];
    logic [7:0]  log_cmd[$];
    logic [31:0] log_wd[$];
    int          exp_steps = 0;
    int          eng_idx = 0;
    bit          eng_final = 1'b0;
    bit          mon_on = 1'b0;

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] mk_cmd(input bit ap, input bit rd, input logic [1:0] a);
        int ones;
        ones = int'(ap) + int'(rd) + int'(a[0]) + int'(a[1]);
        return {1'b1, 1'b0, (ones % 2 == 1), a[1], a[0], rd, ap, 1'b1};
    endfunction

    // Engine model: serves one request per acknowledge
    initial begin
        forever begin
            int lat;
            logic [2:0] st;
            logic [31:0] dat;
            @(negedge clk);
            xact_ack  = 1'b0;
            eng_final = 1'b0;
            if (xact_req) begin
                lat = 1; st = OK; dat = '0;
                if (rsp_lat.size() > 0) begin
                    lat = rsp_lat.pop_front();
                    st  = rsp_st.pop_front();
                    dat = rsp_dat.pop_front();
                end
                log_cmd.push_back(xact_cmd);
                log_wd.push_back(xact_wdata);
                repeat (lat) @(negedge clk);
                xact_ack    = 1'b1;
                xact_status = st;
                xact_rdata  = dat;
                eng_final   = (st != OK) || (eng_idx == exp_steps - 1);
                eng_idx++;
            end
        end
    end

    // Per-clock reference model of ready and done (R10, R11)
    initial begin
        bit busy_m;
        bit rdy_prev;
        busy_m = 1'b0;
        rdy_prev = 1'b1;
        forever begin
            @(posedge clk);
            #(CLK_P/4);
            if (mon_on) begin
                if (eng_final) busy_m = 1'b0;
                else if (op_start && rdy_prev) busy_m = 1'b1;
                if (op_done !== eng_final)
                    chk(1'b0, "R10 done timing", 32'(op_done), 32'(eng_final));
                if (op_ready !== !busy_m)
                    chk(1'b0, "R11 ready vs model", 32'(op_ready), 32'(!busy_m));
                rdy_prev = op_ready;
            end
        end
    end

    // One operation: script responses, run it, compare sequence and result
    task automatic run_op(input logic [1:0] kind, input logic [15:0] addr, input logic [31:0] wd,
                          input int fail_at, input logic [2:0] fail_st, input logic [31:0] rd,
                          input int lat0, input bit poke, input string tag);
        logic [7:0]  ecmd[$];
        logic [31:0] ewd[$];
        bit          wchk[$];
        int          n, got, cyc;
        logic [2:0]  est;
        ecmd.delete(); ewd.delete(); wchk.delete();
        if (kind >= 2) begin
            ecmd.push_back(8'h81);
            ewd.push_back((kind == 3) ? 32'h1F : 32'h1E);
            wchk.push_back(1'b1);
        end else begin
            ecmd.push_back(mk_cmd(0, 0, 2'b10));
            ewd.push_back({addr[15:8], 16'h0, addr[7:4], 4'h0});
            wchk.push_back(1'b1);
            ecmd.push_back(mk_cmd(1, kind == 0, addr[3:2]));
            ewd.push_back(wd);
            wchk.push_back(kind == 1);
            ecmd.push_back(mk_cmd(0, 1, 2'b11));
            ewd.push_back('0);
            wchk.push_back(1'b0);
        end
        exp_steps = ecmd.size();
        n = (fail_at >= 0) ? fail_at + 1 : exp_steps;
        est = (fail_at >= 0) ? fail_st : OK;
        for (int i = 0; i < exp_steps; i++) begin
            rsp_lat.push_back((lat0 + i) % 3);
            rsp_st.push_back((i == fail_at) ? fail_st : OK);
            rsp_dat.push_back((i == exp_steps - 1) ? rd : 32'hBAD0_0000 + i);
        end
        log_cmd.delete(); log_wd.delete();
        eng_idx = 0;
        @(negedge clk);
        op_start = 1'b1; op_kind = kind; op_addr = addr; op_wdata = wd;
        @(negedge clk);
        op_start = 1'b0;
        if (poke) begin
            @(negedge clk);
            op_start = 1'b1; op_kind = 2'd3; op_addr = 16'hFFFF; op_wdata = '1;
            @(negedge clk);
            op_start = 1'b0;
        end
        cyc = 0;
        while (!op_done && cyc < 200) begin
            @(negedge clk);
            cyc++;
        end
        chk(op_done, {tag, " done seen"}, 32'(op_done), 32'd1);
        chk(op_status == est, {tag, " status"}, 32'(op_status), 32'(est));
        if (kind == 0)
            chk(op_rdata == ((est == OK) ? rd : 32'h0), {tag, " rdata"}, op_rdata, (est == OK) ? rd : 32'h0);
        got = log_cmd.size();
        chk(got == n, {tag, " request count"}, 32'(got), 32'(n));
        for (int i = 0; i < n && i < got; i++) begin
            chk(log_cmd[i] == ecmd[i], {tag, " request byte"}, 32'(log_cmd[i]), 32'(ecmd[i]));
            if (wchk[i])
                chk(log_wd[i] == ewd[i], {tag, " request word"}, log_wd[i], ewd[i]);
        end
        rsp_lat.delete(); rsp_st.delete(); rsp_dat.delete();
        @(negedge clk);
    endtask

    // Watchdog: a hung run ends as a failure
    initial begin
        repeat (20000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(op_ready == 1'b1, "R1 ready in reset", 32'(op_ready), 32'd1);
        rst_n = 1'b1;
        @(negedge clk);
        chk(op_ready == 1'b1 && !xact_req && !op_done, "R1 idle after reset",
            {29'd0, op_ready, xact_req, op_done}, 32'b100);
        mon_on = 1'b1;
        // R2 R3 R4 R5: writes with different fields and latencies
        run_op(2'd1, 16'h12F4, 32'hCAFE_0001, -1, OK, '0, 1, 0, "R5 write a=01");
        run_op(2'd1, 16'h0000, 32'h0000_0000, -1, OK, '0, 0, 0, "R5 write a=00");
        // R4 R6: reads return read-buffer data, not pipelined access data
        run_op(2'd0, 16'h0A3C, 32'h0, -1, OK, 32'h1234_5678, 2, 0, "R6 read a=11");
        run_op(2'd0, 16'hFF08, 32'h0, -1, OK, 32'h8765_4321, 0, 0, "R6 read a=10");
        // R7: both abort commands
        run_op(2'd2, 16'hABCD, 32'h0, -1, OK, '0, 1, 0, "R7 clear sticky");
        run_op(2'd3, 16'h0000, 32'h0, -1, OK, '0, 2, 0, "R7 abort ap");
        // R8: non-OK codes stop the sequence at each step position
        run_op(2'd1, 16'h5550, 32'h0F0F_0F0F, 1, WT, '0, 1, 0, "R8 wait on ap write");
        run_op(2'd0, 16'h3370, 32'h0, 0, FT, 32'h1111_1111, 0, 0, "R8 fault on select");
        run_op(2'd0, 16'h7714, 32'h0, 2, FT, 32'h2222_2222, 1, 0, "R8 fault on read buffer");
        run_op(2'd3, 16'h0000, 32'h0, 0, 3'b111, '0, 1, 0, "R8 odd code on abort");
        // R9 R11: start during a busy operation is ignored
        run_op(2'd0, 16'hC0DC, 32'h0, -1, OK, 32'h5A5A_A5A5, 2, 1, "R11 busy start ignored");
        run_op(2'd1, 16'h9988, 32'hDEAD_BEEF, -1, OK, '0, 0, 1, "R9 R11 write after poke");
        mon_on = 1'b0;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule